// File: doc/BRIEF.md
# Manchester Receive Decoder with Preamble Clock Acquisition

This block turns an oversampled, already-sliced serial line into a recovered bit strobe and NRZ data. The line is sampled once per clock at a fixed number of samples per bit. Short pulses are discarded by a width filter. A carrier-sense output rises once two transitions arrive with Manchester-like spacing. After carrier sense, a counter-based recovery timer runs an acquisition sequence on the alternating 1-0 preamble. The timer is stopped and restarted on the centre of the first Manchester '0'. It is then aligned on the centre of the second '0', two bit times later. Data and strobe are enabled a quarter of a bit into the following cell.

Bit encoding on the line: a '0' is high in the first half and low in the second half, so the mid-cell transition falls. A '1' is low then high. The decoded value is the level of the second half. While no frame is present, the recovery timer wraps freely at the bit period, in step with the local transmit timing. The data output rests high. Carrier is lost after two bit times without a transition, and the block returns to idle for the next frame.

Top module: `manch_rx_acq`

## Requirements
- R1: A level on `rxIn` that lasts fewer than 3 consecutive samples is ignored. A train of such pulses on an idle line raises no carrier sense and no strobe. Such a pulse inside a bit cell does not change the decoded bits.
- R2: Carrier sense rises only after two filtered transitions spaced 8±3 or 16±3 samples apart. A single isolated transition, or transitions spaced 4 or 24 samples apart, leave it low.
- R3: Lock needs two falling mid-cell transitions ('0' centres) 32±3 samples apart after carrier sense, as on a 1010 preamble. A stream of all '1' or all '0' bits raises carrier sense but never `dataValid`.
- R4: `dataValid` rises 12 samples (a quarter into cell 5) after the locking transition. On nominal 16-sample cells this is exactly 8 clocks before the first `bitStrobe`. `dataValid` is never high without carrier sense.
- R5: After reset `carrierSense`, `dataValid` and `bitStrobe` are 0 and `rxData` is 1. Whenever `dataValid` is 0, `rxData` is 1 and `bitStrobe` stays 0.
- R6: Once locked, `bitStrobe` pulses for one clock per received bit, starting with bit 5 of the frame. It pulses only for cells that had a mid-cell transition. `rxData` then holds the second-half level of that bit.
- R7: The recovery timer re-aligns on every mid-cell transition that falls within ±3 samples of the predicted centre. Frames with 15- or 17-sample cells decode correctly, and consecutive strobes are at least 13 clocks apart.
- R8: When no filtered transition has been seen for 32 samples, `carrierSense` and `dataValid` fall and `rxData` returns to 1. Both are still high 20 samples after the last transition.
- R9: After a carrier loss the block is idle again, and a following frame is acquired and decoded in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one edge per line sample |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Sliced receive line, synchronous to clk |
| carrierSense | output | 1 | Manchester activity present |
| dataValid | output | 1 | Recovered clock and data enabled |
| bitStrobe | output | 1 | One-clock pulse per decoded bit |
| rxData | output | 1 | Decoded NRZ bit; high while not valid |

## Verification
The assertions check on every cycle the output relations that hold in any state. A strobe never appears outside the valid window, the data rests high when not valid, and valid implies carrier. They also check that a strobe is a single clock wide, that strobes keep a minimum spacing, that a lost carrier drops on the next clock, and that the filter only ever adopts a level the input really carried. Only the bench's scenarios can show the rest. These are which bit the first strobe belongs to, the exact quarter-bit lead of `dataValid`, the rejection of non-preamble patterns and wrong transition spacings, the decoded values under cell-length drift and glitches, and clean reacquisition of a second frame.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic tmrAlign;   // this cycle is phase 0 of the recovery timer
    logic tmrWrap;    // timer wraps at the bit period (else counts up, saturating)
    logic sampleEn;   // capture the filtered line as the decoded bit
    logic forceIdle;  // return data output to its resting level
  } rxmCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CAND = 3'd1,
    ST_HUNT = 3'd2,
    ST_ACQ  = 3'd3,
    ST_LOCK = 3'd4,
    ST_RUN  = 3'd5
  } rxmState_t;

endpackage

// File: rtl/manch_rx_dp.sv
module manch_rx_dp
  import manch_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int NOISE_MIN = 3,
  parameter int LOSS      = 32,
  parameter int TMR_W     = 6,
  parameter int GAP_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  rxmCtl_t          ctl,
  output logic             edgeSeen,
  output logic             fallSeen,
  output logic [TMR_W-1:0] timer,
  output logic [GAP_W-1:0] gap,
  output logic             gapExpired,
  output logic             bitStrobe,
  output logic             rxData
);

  logic rawQ;
  logic lineF;
  logic lineD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ  <= 1'b1;
      lineD <= 1'b1;
    end else begin
      rawQ  <= rxIn;
      lineD <= lineF;
    end
  end

  // pulse-width filter: the line adopts a new level only after it persisted
  generate
    if (NOISE_MIN > 1) begin : g_filt
      localparam int FW = $clog2(NOISE_MIN);
      logic [FW-1:0] runLen;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          runLen <= '0;
          lineF  <= 1'b1;
        end else if (rawQ == lineF) begin
          runLen <= '0;
        end else if (runLen == FW'(NOISE_MIN - 1)) begin
          lineF  <= rawQ;
          runLen <= '0;
        end else begin
          runLen <= runLen + FW'(1);
        end
      end
    end else begin : g_nofilt
      always_ff @(posedge clk) begin
        if (!rstN) lineF <= 1'b1;
        else       lineF <= rawQ;
      end
    end
  endgenerate

  assign edgeSeen   = lineF ^ lineD;
  assign fallSeen   = lineD & ~lineF;
  assign gapExpired = (int'(gap) >= LOSS);

  // samples since the last filtered transition, saturating at the loss limit
  always_ff @(posedge clk) begin
    if (!rstN)                     gap <= GAP_W'(LOSS);
    else if (edgeSeen)             gap <= GAP_W'(1);
    else if (int'(gap) < LOSS)     gap <= gap + GAP_W'(1);
  end

  // recovery timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (ctl.tmrAlign) begin
      timer <= TMR_W'(1);
    end else if (ctl.tmrWrap) begin
      timer <= (int'(timer) >= OSR - 1) ? '0 : timer + TMR_W'(1);
    end else if (timer != '1) begin
      timer <= timer + TMR_W'(1);
    end
  end

  // decoded output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitStrobe <= 1'b0;
      rxData    <= 1'b1;
    end else begin
      bitStrobe <= ctl.sampleEn;
      if (ctl.forceIdle)     rxData <= 1'b1;
      else if (ctl.sampleEn) rxData <= lineF;
    end
  end

  AST_FILTER_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (lineF != lineD) |-> ($past(rawQ) == lineF)) else $error("filter took a level not on the input"); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe) else $error("strobe wider than one clock"); // R6

endmodule

// File: rtl/manch_rx_ctl.sv
module manch_rx_ctl
  import manch_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int TOL   = 3,
  parameter int TMR_W = 6,
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             edgeSeen,
  input  logic             fallSeen,
  input  logic [TMR_W-1:0] timer,
  input  logic [GAP_W-1:0] gap,
  input  logic             gapExpired,
  output rxmCtl_t          ctl,
  output logic             carrierSense,
  output logic             dataValid
);

  localparam int HALF      = OSR / 2;
  localparam int ACQ_SPAN  = 2 * OSR;
  localparam int SAMPLE_PH = OSR / 4;
  localparam int EN_PH     = OSR - OSR / 4;

  rxmState_t state, nxt;
  logic      midSeen;
  logic      setMid;
  logic      inGapWin, inAcqWin, inMidWin;
  int        gapInt, tmrInt;

  assign gapInt   = int'(gap);
  assign tmrInt   = int'(timer);
  assign inGapWin = (gapInt >= HALF - TOL && gapInt <= HALF + TOL) ||
                    (gapInt >= OSR - TOL  && gapInt <= OSR + TOL);
  assign inAcqWin = (tmrInt >= ACQ_SPAN - TOL) && (tmrInt <= ACQ_SPAN + TOL);
  assign inMidWin = (tmrInt >= OSR - TOL) || (tmrInt <= TOL);

  always_comb begin
    nxt         = state;
    ctl         = '0;
    ctl.tmrWrap = (state != ST_ACQ);
    setMid      = 1'b0;
    if (state != ST_IDLE && gapExpired) begin
      nxt           = ST_IDLE;
      ctl.forceIdle = 1'b1;
      ctl.tmrWrap   = 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (edgeSeen) nxt = ST_CAND;
        ST_CAND: if (edgeSeen && inGapWin) nxt = ST_HUNT;
        ST_HUNT: if (fallSeen) begin
          ctl.tmrAlign = 1'b1;
          nxt          = ST_ACQ;
        end
        ST_ACQ: if (fallSeen) begin
          ctl.tmrAlign = 1'b1;
          if (inAcqWin) nxt = ST_LOCK;
        end
        ST_LOCK: if (tmrInt == EN_PH) nxt = ST_RUN;
        ST_RUN: begin
          if (edgeSeen && inMidWin) begin
            ctl.tmrAlign = 1'b1;
            setMid       = 1'b1;
          end
          if (tmrInt == SAMPLE_PH && midSeen) ctl.sampleEn = 1'b1;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      midSeen      <= 1'b0;
      carrierSense <= 1'b0;
      dataValid    <= 1'b0;
    end else begin
      state        <= nxt;
      midSeen      <= (nxt == ST_RUN) && (setMid || (midSeen && !ctl.sampleEn));
      carrierSense <= (nxt != ST_IDLE) && (nxt != ST_CAND);
      dataValid    <= (nxt == ST_RUN);
    end
  end

  AST_CARRIER_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (carrierSense && gapExpired) |=> !carrierSense) else $error("carrier held after silence"); // R8

  AST_VALID_AFTER_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(carrierSense)) else $error("valid without prior carrier"); // R4

endmodule

// File: rtl/manch_rx_acq.sv
module manch_rx_acq
  import manch_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int NOISE_MIN = 3,
  parameter int TOL       = 3,
  parameter int LOSS_BITS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  output logic carrierSense,
  output logic dataValid,
  output logic bitStrobe,
  output logic rxData
);

  localparam int LOSS  = LOSS_BITS * OSR;
  localparam int TMR_W = $clog2(2 * OSR + TOL + 2);
  localparam int GAP_W = $clog2(LOSS + 1);
  localparam int SPC_W = $clog2(4 * OSR);

  rxmCtl_t          ctl;
  logic             edgeSeen, fallSeen, gapExpired;
  logic [TMR_W-1:0] timer;
  logic [GAP_W-1:0] gap;

  manch_rx_dp #(
    .OSR(OSR), .NOISE_MIN(NOISE_MIN), .LOSS(LOSS), .TMR_W(TMR_W), .GAP_W(GAP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .ctl(ctl),
    .edgeSeen(edgeSeen), .fallSeen(fallSeen), .timer(timer), .gap(gap),
    .gapExpired(gapExpired), .bitStrobe(bitStrobe), .rxData(rxData)
  );

  manch_rx_ctl #(
    .OSR(OSR), .TOL(TOL), .TMR_W(TMR_W), .GAP_W(GAP_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .edgeSeen(edgeSeen), .fallSeen(fallSeen),
    .timer(timer), .gap(gap), .gapExpired(gapExpired), .ctl(ctl),
    .carrierSense(carrierSense), .dataValid(dataValid)
  );

  // strobe spacing tracker for the spacing check
  logic [SPC_W-1:0] sinceStrobe;
  logic             sawStrobe;

  always_ff @(posedge clk) begin
    if (!rstN || !dataValid) begin
      sinceStrobe <= '0;
      sawStrobe   <= 1'b0;
    end else if (bitStrobe) begin
      sinceStrobe <= SPC_W'(1);
      sawStrobe   <= 1'b1;
    end else if (sinceStrobe != '1) begin
      sinceStrobe <= sinceStrobe + SPC_W'(1);
    end
  end

  AST_STROBE_IN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> dataValid) else $error("strobe outside valid window"); // R5

  AST_DATA_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> rxData) else $error("data low while not valid"); // R5

  AST_VALID_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> carrierSense) else $error("valid without carrier"); // R4

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && sawStrobe) |-> (int'(sinceStrobe) >= OSR - TOL)) else $error("strobes too close"); // R7

endmodule

// File: tb/manch_rx_acq_tb.sv
`timescale 1ns/1ps
module manch_rx_acq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic carrierSense, dataValid, bitStrobe, rxData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit expQ[$];
  bit leadCheckOn = 0;
  bit leadPending = 0;
  int validAt = 0;
  bit sawValid = 0;
  bit sawStrobe = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc++;

  manch_rx_acq u_dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn),
    .carrierSense(carrierSense), .dataValid(dataValid),
    .bitStrobe(bitStrobe), .rxData(rxData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid) sawValid = 1;
      if (dataValid && !prevValid) begin
        validAt     = cyc;
        leadPending = 1;
      end
      if (bitStrobe) begin
        sawStrobe = 1;
        if (leadPending && leadCheckOn)
          chk("R4 valid lead before first strobe", cyc - validAt, 8);
        leadPending = 0;
        if (expQ.size() == 0) begin
          chk("R6 unexpected strobe", 1, 0);
        end else begin
          chk("R6 decoded bit", rxData, expQ.pop_front());
        end
      end
    end
    prevValid = dataValid;
  end

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxIn = v;
    end
  endtask

  task automatic sendBit(input bit b, input int h1, input int h2, input bit glitch);
    if (glitch && h1 >= 7) begin
      drive(~b, 3);
      drive(b, 2);          // R1 two-sample pulse inside the first half
      drive(~b, h1 - 5);
    end else begin
      drive(~b, h1);
    end
    drive(b, h2);
  endtask

  task automatic sendFrame(input int preLen, input logic [15:0] pay,
                           input int h1, input int h2, input bit glitch);
    int k;
    bit b;
    k = 1;
    for (int i = 0; i < preLen; i++) begin
      b = (i % 2 == 0);
      if (k >= 5) expQ.push_back(b);
      sendBit(b, h1, h2, 1'b0);
      k++;
    end
    for (int i = 15; i >= 0; i--) begin
      b = pay[i];
      if (k >= 5) expQ.push_back(b);
      sendBit(b, h1, h2, glitch);
      k++;
    end
  endtask

  task automatic endFrame(input int h2);
    drive(rxIn, 20 - h2);
    chk("R8 carrier still up shortly after last transition", carrierSense, 1);
    drive(rxIn, 28);
    chk("R8 carrier dropped", carrierSense, 0);
    chk("R8 valid dropped", dataValid, 0);
    chk("R8 data rests high", rxData, 1);
    chk("R6 all expected bits strobed", expQ.size(), 0);
    expQ.delete();
    drive(1'b1, 60);
    chk("R9 idle before next frame", carrierSense, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R5 reset carrier", carrierSense, 0);
    chk("R5 reset valid", dataValid, 0);
    chk("R5 reset strobe", bitStrobe, 0);
    chk("R5 reset data", rxData, 1);
    drive(1'b1, 20);

    // R1 short pulses on idle line
    sawStrobe = 0;
    for (int i = 0; i < 10; i++) begin
      drive(1'b0, 2);
      drive(1'b1, 6);
    end
    drive(1'b1, 10);
    chk("R1 no carrier from short pulses", carrierSense, 0);
    chk("R1 no strobe from short pulses", sawStrobe, 0);

    // R2 isolated transitions and bad spacing
    drive(1'b0, 80);
    chk("R2 single transition no carrier", carrierSense, 0);
    drive(1'b1, 80);
    chk("R2 second isolated transition no carrier", carrierSense, 0);
    for (int i = 0; i < 10; i++) drive(i % 2 == 0 ? 1'b0 : 1'b1, 4);
    chk("R2 spacing 4 no carrier", carrierSense, 0);
    drive(1'b1, 60);
    for (int i = 0; i < 6; i++) drive(i % 2 == 0 ? 1'b0 : 1'b1, 24);
    chk("R2 spacing 24 no carrier", carrierSense, 0);
    drive(1'b1, 60);

    // R3 all ones, then all zeros: carrier but no lock
    sawValid = 0;
    sawStrobe = 0;
    for (int i = 0; i < 8; i++) sendBit(1'b1, 8, 8, 1'b0);
    chk("R2 carrier on all-ones stream", carrierSense, 1);
    chk("R3 no lock on all-ones", sawValid, 0);
    drive(1'b1, 60);
    for (int i = 0; i < 8; i++) sendBit(1'b0, 8, 8, 1'b0);
    chk("R2 carrier on all-zeros stream", carrierSense, 1);
    chk("R3 no lock on all-zeros", sawValid, 0);
    chk("R5 no strobe without lock", sawStrobe, 0);
    drive(1'b1, 60);
    chk("R8 carrier gone after silence", carrierSense, 0);

    // R4 R6 nominal frame with minimal preamble
    leadCheckOn = 1;
    sawValid = 0;
    sendFrame(4, 16'hA5C3, 8, 8, 1'b0);
    chk("R3 locked on 1010 preamble", sawValid, 1);
    endFrame(8);

    // R9 longer preamble, reacquire
    sendFrame(8, 16'h0F31, 8, 8, 1'b0);
    endFrame(8);
    leadCheckOn = 0;

    // R7 slow cells (17 samples) and fast cells (15 samples)
    sendFrame(4, 16'h5E27, 9, 8, 1'b0);
    endFrame(8);
    sendFrame(6, 16'hC18B, 8, 7, 1'b0);
    endFrame(7);

    // R1 glitches inside payload cells
    sendFrame(4, 16'h3D96, 8, 8, 1'b1);
    endFrame(8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule